// File: doc/BRIEF.md
# Instruction Cycle Wait-State Sequencer

This block paces a small processor core through its instruction cycles. Every instruction begins with a one-cycle decode phase. Instructions that touch data memory then spend one cycle latching the address. All instructions finish in a completion phase that lasts one cycle more than a programmed wait count. At the end of that phase the block pulses exactly one action strobe (result store, data read or data write, or none) together with an instruction prefetch strobe, and the next decode follows.

A five-bit wait field sets the stretch. Its low three bits hold the data-memory wait count and its top two bits hold the instruction wait count. The core drives the instruction class and, for an absolute jump, a condition-failed flag during the decode cycle. An absolute jump finishes its first completion phase with a prefetch. It then passes through either a jump-load cycle or a skip cycle, and a second completion phase at the instruction wait count follows. ALU work, memory contents and branch targets are handled elsewhere; this block only provides the timing strobes.

Top module: `instr_wait_seq`

## Requirements
- R1: A synchronous reset puts the block in a start cycle that drives no strobe. After reset is released, the start cycle is followed by a completion phase of (instruction waits + 1) cycles that ends in a prefetch. The first decode strobe therefore appears instruction-waits + 2 cycles after the start cycle.
- R2: Bits 2:0 of `cfg_wait` are the data-memory waits (0 to 7). Bits 4:3 are the instruction waits (0 to 3).
- R3: For the class codes next (0) and store (1), the completion phase lasts instruction-waits + 1 cycles, and the next decode comes instruction-waits + 2 cycles after the current one.
- R4: For the class codes read (2) and write (3), an address-latch strobe is raised in the cycle right after decode. The wait count is the data-memory waits when the instruction waits are 0, and max(data waits, instruction waits − 1) otherwise. The next decode comes that count + 3 cycles after the current one.
- R5: The action strobe of a store, read or write is raised in the same cycle as the prefetch that ends the completion phase. Each such instruction raises exactly one action strobe, for one cycle. The classes next and absolute raise none.
- R6: For the class code absolute (4) with the fail flag low, a prefetch ends a first completion phase of instruction-waits + 1 cycles. A one-cycle jump strobe follows, then a second completion phase of the same length that also ends in a prefetch. The next decode comes 2·instruction-waits + 4 cycles after the current one.
- R7: For the class absolute with the fail flag high, a skip strobe is raised in place of the jump strobe, with the same timing as R6.
- R8: The class codes 5, 6 and 7 behave exactly like next.
- R9: The fail flag has no effect on any class other than absolute.
- R10: Each decode strobe lasts one cycle. In the completion phase the wait count goes down by one per cycle until it reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wait | input | 5 | Wait configuration: [2:0] data waits, [4:3] instruction waits |
| ins_class | input | 3 | Instruction class, sampled in the decode cycle |
| ins_fail | input | 1 | Absolute-jump condition failed, sampled in the decode cycle |
| ale_o | output | 1 | Address-latch strobe |
| store_o | output | 1 | Store-result strobe |
| rd_o | output | 1 | Data-read strobe |
| wr_o | output | 1 | Data-write strobe |
| prefetch_o | output | 1 | Instruction prefetch strobe |
| decode_o | output | 1 | Decode strobe |
| skip_o | output | 1 | Skip strobe (advance one extra word) |
| jump_o | output | 1 | Jump-load strobe |

## Verification
The bench targets the wait formula at its edges. With zero instruction waits, a design that subtracted one anyway would wrap to a huge count and hang the core. With instruction waits of 3 and no data waits, a design that ignored the instruction waits would shorten memory cycles. The bench also checks that the action strobe lines up with the prefetch cycle, since a design that fired one cycle early or late would pulse its action and its prefetch apart. Absolute jumps are checked for the double prefetch and for the skip-versus-jump choice. Unused class codes and a stray fail flag are checked for leaking into the timing.

// File: rtl/instr_wait_seq.sv
module instr_wait_seq #(
  parameter int DW_W = 3,
  parameter int IW_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW_W+IW_W-1:0] cfg_wait,
  input  logic [2:0]           ins_class,
  input  logic                 ins_fail,
  output logic                 ale_o,
  output logic                 store_o,
  output logic                 rd_o,
  output logic                 wr_o,
  output logic                 prefetch_o,
  output logic                 decode_o,
  output logic                 skip_o,
  output logic                 jump_o
);
  localparam int CNT_W = (DW_W > IW_W) ? DW_W : IW_W;
  localparam logic [2:0] CLS_STORE = 3'd1;
  localparam logic [2:0] CLS_READ  = 3'd2;
  localparam logic [2:0] CLS_WRITE = 3'd3;
  localparam logic [2:0] CLS_ABS   = 3'd4;

  typedef enum logic [2:0] {ST_START, ST_DECODE, ST_ADDR, ST_T2, ST_SKIP, ST_JUMP} st_t;
  typedef enum logic [2:0] {AC_NONE, AC_STORE, AC_READ, AC_WRITE, AC_ABS} act_t;

  st_t              st;
  act_t             act;
  logic [CNT_W-1:0] wcnt;
  logic             fail_q;

  logic [CNT_W-1:0] dw, iw, iw_m1, mem_w;
  logic             done;

  assign dw    = CNT_W'(cfg_wait[DW_W-1:0]);
  assign iw    = CNT_W'(cfg_wait[DW_W +: IW_W]);
  assign iw_m1 = iw - 1'b1;
  assign mem_w = (iw == '0) ? dw : ((dw > iw_m1) ? dw : iw_m1);
  assign done  = (st == ST_T2) && (wcnt == '0);

  assign decode_o   = (st == ST_DECODE);
  assign ale_o      = (st == ST_ADDR);
  assign skip_o     = (st == ST_SKIP);
  assign jump_o     = (st == ST_JUMP);
  assign prefetch_o = done;
  assign store_o    = done && (act == AC_STORE);
  assign rd_o       = done && (act == AC_READ);
  assign wr_o       = done && (act == AC_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_START;
      act    <= AC_NONE;
      wcnt   <= '0;
      fail_q <= 1'b0;
    end else begin
      case (st)
        ST_START, ST_SKIP, ST_JUMP: begin
          wcnt <= iw;
          act  <= AC_NONE;
          st   <= ST_T2;
        end
        ST_DECODE: begin
          fail_q <= ins_fail;
          case (ins_class)
            CLS_READ:  begin act <= AC_READ;  st <= ST_ADDR; end
            CLS_WRITE: begin act <= AC_WRITE; st <= ST_ADDR; end
            CLS_STORE: begin act <= AC_STORE; wcnt <= iw; st <= ST_T2; end
            CLS_ABS:   begin act <= AC_ABS;   wcnt <= iw; st <= ST_T2; end
            default:   begin act <= AC_NONE;  wcnt <= iw; st <= ST_T2; end
          endcase
        end
        ST_ADDR: begin
          wcnt <= mem_w;
          st   <= ST_T2;
        end
        ST_T2: begin
          if (wcnt != '0) wcnt <= wcnt - 1'b1;
          else if (act == AC_ABS) st <= fail_q ? ST_SKIP : ST_JUMP;
          else st <= ST_DECODE;
        end
        default: st <= ST_START;
      endcase
    end
  end

  p_reset_start_r1: assert property (@(posedge clk)
    rst |=> (st == ST_START && wcnt == '0 && !prefetch_o && !decode_o));

  p_one_action_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_o, rd_o, wr_o}));

  p_action_with_prefetch_r5: assert property (@(posedge clk) disable iff (rst)
    (store_o || rd_o || wr_o) |-> prefetch_o);

  p_ale_then_t2_r4: assert property (@(posedge clk) disable iff (rst)
    ale_o |=> (st == ST_T2 && !ale_o && wcnt == $past(mem_w)));

  p_prefetch_next_r6: assert property (@(posedge clk) disable iff (rst)
    prefetch_o |=> (decode_o || skip_o || jump_o));

  p_decode_single_r10: assert property (@(posedge clk) disable iff (rst)
    decode_o |=> !decode_o);

  p_countdown_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_T2 && wcnt != '0) |=> (st == ST_T2 && wcnt == $past(wcnt) - 1'b1));
endmodule

// File: tb/instr_wait_seq_tb.sv
module instr_wait_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] cfg_wait = 5'd0;
  logic [2:0] ins_class = 3'd0;
  logic       ins_fail = 1'b0;
  logic ale_o, store_o, rd_o, wr_o, prefetch_o, decode_o, skip_o, jump_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_wait_seq dut_i (
    .clk(clk), .rst(rst), .cfg_wait(cfg_wait), .ins_class(ins_class), .ins_fail(ins_fail),
    .ale_o(ale_o), .store_o(store_o), .rd_o(rd_o), .wr_o(wr_o),
    .prefetch_o(prefetch_o), .decode_o(decode_o), .skip_o(skip_o), .jump_o(jump_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int iw_of(input logic [4:0] c); return int'(c[4:3]); endfunction
  function automatic int dw_of(input logic [4:0] c); return int'(c[2:0]); endfunction
  function automatic int mem_waits(input logic [4:0] c);
    int i = iw_of(c);
    int d = dw_of(c);
    if (i == 0) return d;
    return (d > i - 1) ? d : i - 1;
  endfunction

  task automatic do_reset(input logic [4:0] c);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({ale_o, store_o, rd_o, wr_o, prefetch_o, decode_o, skip_o, jump_o} == 8'd0,
          "R1", int'({ale_o, store_o, rd_o, wr_o, prefetch_o, decode_o, skip_o, jump_o}), 0);
    cfg_wait = c;
    rst = 1'b0;
    begin
      int n = 0;
      int pf = -1;
      while (n < 40) begin
        @(negedge clk);
        n++;
        if (prefetch_o && pf < 0) pf = n;
        if (decode_o) break;
      end
      check(n == iw_of(c) + 2, "R1", n, iw_of(c) + 2);
      check(pf == iw_of(c) + 1, "R1", pf, iw_of(c) + 1);
    end
  endtask

  // Called at a negedge where decode_o is high.
  task automatic run_ins(input logic [2:0] cls, input bit fl, input logic [4:0] c);
    int n = 0, ale_n = 0, ale_p = -1, pf_n = 0, pf_p = -1, cmp_n = 0, cmp_p = -1;
    int cmp_k = -1, skip_n = 0, skip_p = -1, jump_n = 0, jump_p = -1;
    int iw = iw_of(c);
    int mw = mem_waits(c);
    int exp_n, exp_pf, exp_k;
    string rq;
    ins_class = cls;
    ins_fail = fl;
    cfg_wait = c;
    while (n < 80) begin
      @(negedge clk);
      n++;
      if (decode_o) break;
      if (ale_o) begin ale_n++; if (ale_p < 0) ale_p = n; end
      if (prefetch_o) begin pf_n++; if (pf_p < 0) pf_p = n; end
      if (store_o) begin cmp_n++; cmp_k = 1; cmp_p = n; end
      if (rd_o) begin cmp_n++; cmp_k = 2; cmp_p = n; end
      if (wr_o) begin cmp_n++; cmp_k = 3; cmp_p = n; end
      if (skip_o) begin skip_n++; skip_p = n; end
      if (jump_o) begin jump_n++; jump_p = n; end
    end
    case (cls)
      3'd1: begin rq = fl ? "R9" : "R3"; exp_n = iw + 2; exp_pf = iw + 1; exp_k = 1; end
      3'd2: begin rq = fl ? "R9" : "R4"; exp_n = mw + 3; exp_pf = mw + 2; exp_k = 2; end
      3'd3: begin rq = fl ? "R9" : "R4"; exp_n = mw + 3; exp_pf = mw + 2; exp_k = 3; end
      3'd4: begin rq = fl ? "R7" : "R6"; exp_n = 2*iw + 4; exp_pf = iw + 1; exp_k = -1; end
      3'd0: begin rq = fl ? "R9" : "R3"; exp_n = iw + 2; exp_pf = iw + 1; exp_k = -1; end
      default: begin rq = "R8"; exp_n = iw + 2; exp_pf = iw + 1; exp_k = -1; end
    endcase
    check(n == exp_n, rq, n, exp_n);
    check(pf_p == exp_pf, rq, pf_p, exp_pf);
    check(pf_n == ((cls == 3'd4) ? 2 : 1), rq, pf_n, (cls == 3'd4) ? 2 : 1);
    if (exp_k > 0) begin
      check(cmp_n == 1 && cmp_k == exp_k, "R5", cmp_k, exp_k);
      check(cmp_p == pf_p, "R5", cmp_p, pf_p);
    end else begin
      check(cmp_n == 0, "R5", cmp_n, 0);
    end
    if (cls == 3'd2 || cls == 3'd3) begin
      check(ale_n == 1 && ale_p == 1, "R4", ale_p, 1);
    end else begin
      check(ale_n == 0, rq, ale_n, 0);
    end
    if (cls == 3'd4) begin
      if (fl) begin
        check(skip_n == 1 && jump_n == 0 && skip_p == iw + 2, "R7", skip_p, iw + 2);
      end else begin
        check(jump_n == 1 && skip_n == 0 && jump_p == iw + 2, "R6", jump_p, iw + 2);
      end
    end else begin
      check(skip_n == 0 && jump_n == 0, rq, skip_n + jump_n, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset(5'b00_000);
    // Directed corners, R2 field split
    run_ins(3'd0, 1'b0, 5'b00_000);
    run_ins(3'd2, 1'b0, 5'b00_000);
    run_ins(3'd3, 1'b0, 5'b11_000);
    run_ins(3'd2, 1'b0, 5'b01_101);
    run_ins(3'd3, 1'b0, 5'b10_001);
    run_ins(3'd2, 1'b0, 5'b00_111);
    run_ins(3'd1, 1'b0, 5'b11_111);
    run_ins(3'd4, 1'b0, 5'b00_000);
    run_ins(3'd4, 1'b1, 5'b11_000);
    run_ins(3'd6, 1'b1, 5'b10_011);
    run_ins(3'd1, 1'b1, 5'b01_000);
    do_reset(5'b11_010);
    for (int k = 0; k < 400; k++) begin
      run_ins(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)));
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule